// File: doc/BRIEF.md
# Processor Mode and Kernel-Entry Monitor

This block sits beside the processor bus and watches every bus cycle. For each valid cycle it reports what kind of cycle it was (user or supervisor, data or program, CPU space or a reserved code), and it cross-checks three sources of mode information against each other. The first source is the three-bit cycle function code. The second is the pair of status pins from the core: an instruction/data pin and a supervisor/user pin. Each pin comes through a pad that also reports whether the pin is floating. The third source is the marker bytes that instrumented kernel code writes to one reserved address.

An entry marker opens a kernel critical section and an exit marker closes one. A four-bit nesting counter tracks how deep the sections are nested. A further marker records that a semaphore-pend call is under way. Any disagreement sets a cause bit in a sticky status register, and the single error output is the OR of those bits. Only a reset clears the register. The value of every marker byte is kept in a last-event register, so software can see the most recent kernel event.

Top module: `kernel_mode_monitor`

## Requirements
- R1: After reset, depth is 0, err_cause and err_flag are 0, last_evt is 0, pend_busy is 0 and class_vld is 0.
- R2: One cycle after each valid bus cycle, class_vld is 1 and cyc_class gives the cycle kind from fc. The mapping is: 001→1 (user data), 010→2 (user program), 101→3 (supervisor data), 110→4 (supervisor program), 111→5 (CPU space), and 000, 011 or 100→6 (reserved). After a cycle with bus_vld low, class_vld is 0.
- R3: A marker write is a valid write to address 0x000100. A marker byte of 11 (decimal) raises depth by 1 and a marker byte of 0 lowers it by 1. Reads of that address and writes to any other address leave depth unchanged.
- R4: An entry marker that arrives with depth at 15 sets err_cause[4] (overflow), and depth stays at 15.
- R5: An exit marker that arrives with depth at 0 sets err_cause[3] (underflow), and depth stays at 0.
- R6: An exit marker written while st_user is driven high (user mode) sets err_cause[5]. The decrement still takes place.
- R7: The first valid cycle after an entry marker must show st_user low (supervisor). If st_user is driven high on that cycle, err_cause[6] is set.
- R8: A valid cycle with st_instr_z or st_user_z high sets err_cause[0]. The value of a floating pin is not used by any other check.
- R9: A valid cycle with a reserved fc (000, 011 or 100) sets err_cause[1].
- R10: On a valid cycle with a non-reserved fc, err_cause[2] is set in either of two cases. The first is a driven st_user that differs from the inverse of fc[2]. The second is a driven st_instr that differs from fc[1], a check that is skipped for fc 111.
- R11: Every marker byte is copied into last_evt. A marker byte other than 11, 0 or 4 changes neither depth nor err_cause.
- R12: Marker byte 4 sets pend_busy. An exit marker that leaves depth at 0 clears it.
- R13: Bits of err_cause stay set until reset, and err_flag is high exactly when any bit of err_cause is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_vld | input | 1 | A bus cycle is present this clock |
| bus_we | input | 1 | The cycle is a write |
| bus_addr | input | AW | Cycle address |
| bus_wdata | input | 8 | Write data byte |
| fc | input | 3 | Cycle function code |
| st_instr | input | 1 | Status pin: 1 instruction, 0 data |
| st_instr_z | input | 1 | Pad reports st_instr floating |
| st_user | input | 1 | Status pin: 1 user, 0 supervisor |
| st_user_z | input | 1 | Pad reports st_user floating |
| cyc_class | output | 3 | Kind of the previous valid cycle |
| class_vld | output | 1 | cyc_class is valid |
| depth | output | DW | Critical-section nesting depth |
| pend_busy | output | 1 | Semaphore-pend call in progress |
| last_evt | output | 8 | Most recent marker byte |
| err_cause | output | 7 | Sticky error cause bits |
| err_flag | output | 1 | Any error recorded |

## Verification
The assertions check several properties on every cycle. Depth moves by at most one step per cycle, and error cause bits never clear outside reset. Overflow and underflow each set their cause bit while depth holds still. A floating pin on a valid cycle is always flagged, and a class report only ever follows a valid cycle. Other behaviour can only be shown by the bench's scenarios, which compare against a model: the class encoding, the supervisor check on the cycle after an entry, exits made from user mode, pend tracking, and the fact that unknown marker bytes are latched but otherwise ignored.

// File: rtl/kernel_mode_monitor.sv
module kernel_mode_monitor #(
  parameter int          AW         = 24,
  parameter int          DW         = 4,
  parameter logic [23:0] MARK_ADDR  = 24'h000100,
  parameter logic [7:0]  ENTER_CODE = 8'd11,
  parameter logic [7:0]  EXIT_CODE  = 8'd0,
  parameter logic [7:0]  PEND_CODE  = 8'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_vld,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic [2:0]    fc,
  input  logic          st_instr,
  input  logic          st_instr_z,
  input  logic          st_user,
  input  logic          st_user_z,
  output logic [2:0]    cyc_class,
  output logic          class_vld,
  output logic [DW-1:0] depth,
  output logic          pend_busy,
  output logic [7:0]    last_evt,
  output logic [6:0]    err_cause,
  output logic          err_flag
);
  localparam logic [DW-1:0] DEPTH_MAX = {DW{1'b1}};
  localparam int E_FLOAT = 0, E_RSVD = 1, E_PIN = 2, E_UNDER = 3,
                 E_OVER = 4, E_UEXIT = 5, E_NOSUP = 6;

  logic       await_sup;
  logic       is_mark, is_enter, is_exit, is_pend;
  logic       fc_rsvd, user_drv;
  logic [6:0] err_now;
  logic [2:0] cls_now;

  assign is_mark  = bus_vld && bus_we && (bus_addr == MARK_ADDR[AW-1:0]);
  assign is_enter = is_mark && (bus_wdata == ENTER_CODE);
  assign is_exit  = is_mark && (bus_wdata == EXIT_CODE);
  assign is_pend  = is_mark && (bus_wdata == PEND_CODE);
  assign fc_rsvd  = (fc == 3'b000) || (fc == 3'b011) || (fc == 3'b100);
  assign user_drv = !st_user_z && st_user;

  always_comb begin
    err_now = '0;
    if (bus_vld) begin
      err_now[E_FLOAT] = st_instr_z || st_user_z;
      err_now[E_RSVD]  = fc_rsvd;
      err_now[E_PIN]   = !fc_rsvd &&
                         ((!st_user_z && (st_user == fc[2])) ||
                          ((fc != 3'b111) && !st_instr_z && (st_instr != fc[1])));
      err_now[E_NOSUP] = await_sup && user_drv;
    end
    err_now[E_UNDER] = is_exit && (depth == '0);
    err_now[E_OVER]  = is_enter && (depth == DEPTH_MAX);
    err_now[E_UEXIT] = is_exit && user_drv;
  end

  always_comb begin
    case (fc)
      3'b001:  cls_now = 3'd1;
      3'b010:  cls_now = 3'd2;
      3'b101:  cls_now = 3'd3;
      3'b110:  cls_now = 3'd4;
      3'b111:  cls_now = 3'd5;
      default: cls_now = 3'd6;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth     <= '0;
      pend_busy <= 1'b0;
      last_evt  <= '0;
      err_cause <= '0;
      await_sup <= 1'b0;
      cyc_class <= '0;
      class_vld <= 1'b0;
    end else begin
      err_cause <= err_cause | err_now;
      class_vld <= bus_vld;
      if (bus_vld) cyc_class <= cls_now;
      if (is_enter) await_sup <= 1'b1;
      else if (bus_vld) await_sup <= 1'b0;
      if (is_mark) last_evt <= bus_wdata;
      if (is_enter && depth != DEPTH_MAX) depth <= depth + 1'b1;
      if (is_exit && depth != '0) depth <= depth - 1'b1;
      if (is_pend) pend_busy <= 1'b1;
      else if (is_exit && depth <= DW'(1)) pend_busy <= 1'b0;
    end
  end

  assign err_flag = |err_cause;
endmodule

// File: rtl/kernel_mode_monitor_chk.sv
module kernel_mode_monitor_chk #(
  parameter int          AW         = 24,
  parameter int          DW         = 4,
  parameter logic [23:0] MARK_ADDR  = 24'h000100,
  parameter logic [7:0]  ENTER_CODE = 8'd11,
  parameter logic [7:0]  EXIT_CODE  = 8'd0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_vld,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          st_instr_z,
  input logic          st_user_z,
  input logic          class_vld,
  input logic [DW-1:0] depth,
  input logic [6:0]    err_cause,
  input logic          err_flag
);
  logic mark;
  assign mark = bus_vld && bus_we && (bus_addr == MARK_ADDR[AW-1:0]);

  // R3
  depth_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((depth == $past(depth)) || (depth == $past(depth) + 1'b1) ||
              (depth == $past(depth) - 1'b1)));

  // R4
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && bus_wdata == ENTER_CODE && depth == {DW{1'b1}}) |=>
      (err_cause[4] && depth == {DW{1'b1}}));

  // R5
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && bus_wdata == EXIT_CODE && depth == '0) |=> (err_cause[3] && depth == '0));

  // R8
  float_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && (st_instr_z || st_user_z)) |=> err_cause[0]);

  // R13
  sticky_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_cause & $past(err_cause)) == $past(err_cause)));

  // R13
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(bus_vld));

  // R2
  class_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    class_vld |-> $past(bus_vld));
endmodule

bind kernel_mode_monitor kernel_mode_monitor_chk #(
  .AW(AW), .DW(DW), .MARK_ADDR(MARK_ADDR), .ENTER_CODE(ENTER_CODE), .EXIT_CODE(EXIT_CODE)
) u_chk (.*);

// File: tb/kernel_mode_monitor_tb.sv
module kernel_mode_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_vld, bus_we;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [2:0]  fc;
  logic        st_instr, st_instr_z, st_user, st_user_z;
  logic [2:0]  cyc_class;
  logic        class_vld, pend_busy, err_flag;
  logic [3:0]  depth;
  logic [7:0]  last_evt;
  logic [6:0]  err_cause;

  kernel_mode_monitor u_dut (.*);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;

  int         m_depth;
  bit         m_pend, m_await, m_cvld;
  logic [7:0] m_last;
  logic [6:0] m_err;
  logic [2:0] m_cls;

  localparam logic [23:0] MK = 24'h000100;

  function automatic logic [2:0] cls_of(logic [2:0] f);
    case (f)
      3'b001: return 3'd1;
      3'b010: return 3'd2;
      3'b101: return 3'd3;
      3'b110: return 3'd4;
      3'b111: return 3'd5;
      default: return 3'd6;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2 class_vld"}, class_vld, m_cvld);
    if (m_cvld) chk({tag, " R2 cyc_class"}, cyc_class, m_cls);
    chk({tag, " R3 depth"}, depth, m_depth);
    chk({tag, " R12 pend_busy"}, pend_busy, m_pend);
    chk({tag, " R11 last_evt"}, last_evt, m_last);
    chk({tag, " R13 err_cause"}, err_cause, m_err);
    chk({tag, " R13 err_flag"}, err_flag, |m_err);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_vld = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; fc = 3'b101;
    st_instr = 0; st_instr_z = 0; st_user = 0; st_user_z = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    m_depth = 0; m_pend = 0; m_await = 0; m_cvld = 0; m_last = '0; m_err = '0; m_cls = '0;
  endtask

  task automatic step(bit v, bit we, logic [23:0] a, logic [7:0] d, logic [2:0] f,
                      bit i, bit iz, bit u, bit uz, string tag);
    bit mark, rsvd;
    logic [6:0] e;
    bus_vld = v; bus_we = we; bus_addr = a; bus_wdata = d; fc = f;
    st_instr = i; st_instr_z = iz; st_user = u; st_user_z = uz;
    e = '0;
    rsvd = (f == 3'b000) || (f == 3'b011) || (f == 3'b100);
    mark = v && we && (a == MK);
    if (v) begin
      if (iz || uz) e[0] = 1;
      if (rsvd) e[1] = 1;
      if (!rsvd && !uz && (u == f[2])) e[2] = 1;
      if (!rsvd && f != 3'b111 && !iz && (i != f[1])) e[2] = 1;
      if (m_await && !uz && u) e[6] = 1;
      m_cls = cls_of(f);
      m_await = 0;
    end
    m_cvld = v;
    if (mark) begin
      m_last = d;
      if (d == 8'd11) begin
        if (m_depth == 15) e[4] = 1; else m_depth++;
        m_await = 1;
      end else if (d == 8'd0) begin
        if (!uz && u) e[5] = 1;
        if (m_depth <= 1) m_pend = 0;
        if (m_depth == 0) e[3] = 1; else m_depth--;
      end else if (d == 8'd4) m_pend = 1;
    end
    m_err = m_err | e;
    @(posedge clk); @(negedge clk);
    check_all(tag);
  endtask

  task automatic ok(logic [2:0] f, bit we, logic [23:0] a, logic [7:0] d, string tag);
    step(1, we, a, d, f, f[1], 0, !f[2], 0, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    check_all("R1 reset");

    // R2 legal classes, then R9 reserved code
    ok(3'b001, 0, 24'h2000, 0, "R2 udata");
    ok(3'b010, 0, 24'h2004, 0, "R2 uprog");
    ok(3'b101, 1, 24'h3000, 8'h12, "R2 sdata");
    ok(3'b110, 0, 24'h3004, 0, "R2 sprog");
    ok(3'b111, 0, 24'hF000, 0, "R2 cpu");
    step(0, 0, 0, 0, 3'b101, 0, 0, 0, 0, "R2 idle");
    ok(3'b011, 0, 24'h2000, 0, "R9 reserved");

    // R3 R11 R12 nesting, unknown byte, pend, read of marker address
    do_reset();
    ok(3'b101, 1, MK, 8'd11, "R3 enter1");
    ok(3'b101, 1, MK, 8'd11, "R3 enter2");
    ok(3'b101, 1, MK, 8'd4, "R12 pend");
    ok(3'b101, 1, MK, 8'h55, "R11 unknown");
    ok(3'b101, 0, MK, 8'd0, "R3 read ignored");
    ok(3'b101, 1, 24'h0104, 8'd11, "R3 other addr");
    ok(3'b101, 1, MK, 8'd0, "R3 exit1");
    ok(3'b101, 1, MK, 8'd0, "R12 exit2");

    // R5 underflow
    do_reset();
    ok(3'b101, 1, MK, 8'd0, "R5 underflow");

    // R4 overflow
    do_reset();
    for (int k = 0; k < 16; k++) ok(3'b101, 1, MK, 8'd11, "R4 fill");
    chk("R4 depth held", depth, 15);
    chk("R4 overflow bit", err_cause[4], 1);

    // R7 user cycle straight after entry
    do_reset();
    ok(3'b101, 1, MK, 8'd11, "R7 enter");
    ok(3'b001, 0, 24'h2000, 0, "R7 user after entry");

    // R6 exit written from user mode
    do_reset();
    ok(3'b101, 1, MK, 8'd11, "R6 enter");
    ok(3'b110, 0, 24'h3000, 0, "R6 sup");
    ok(3'b001, 1, MK, 8'd0, "R6 user exit");

    // R8 floating pin whose value disagrees is only a float error
    do_reset();
    step(1, 0, 24'h3000, 0, 3'b110, 0, 1, 1, 1, "R8 float");

    // R10 instruction pin disagrees with program code
    do_reset();
    step(1, 0, 24'h3000, 0, 3'b110, 0, 0, 0, 0, "R10 pin mismatch");

    // random mix
    for (int r = 0; r < 6; r++) begin
      do_reset();
      for (int n = 0; n < 600; n++) begin
        logic [2:0] f; bit v, we, i, u, iz, uz; logic [23:0] a; logic [7:0] d;
        int p;
        p = $urandom_range(0, 99);
        v = ($urandom_range(0, 9) != 0);
        f = ($urandom_range(0, 19) == 0) ? 3'($urandom) : (($urandom_range(0, 1) == 1) ? 3'b101 : 3'b110);
        i = f[1]; u = !f[2]; iz = 0; uz = 0;
        if ($urandom_range(0, 29) == 0) i = !i;
        if ($urandom_range(0, 29) == 0) u = !u;
        if ($urandom_range(0, 59) == 0) iz = 1;
        if ($urandom_range(0, 59) == 0) uz = 1;
        we = ($urandom_range(0, 1) == 1);
        a = (p < 40) ? MK : 24'($urandom_range(0, 255)) << 4;
        case ($urandom_range(0, 3))
          0, 1: d = 8'd11;
          2: d = 8'd0;
          default: d = ($urandom_range(0, 1) == 1) ? 8'd4 : 8'($urandom);
        endcase
        step(v, we, a, d, f, i, iz, u, uz, "R2-R13 random");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule